// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block sits beside an instruction execution engine and decides, at each instruction boundary, whether the processor must divert into a handler. It weighs four candidates: a non-maskable request, a numbered maskable request, a single-step trap and an invalid-opcode trap. The execution engine pulses `head_i` just before an instruction begins and `tail_i` just after it retires. Both points are arbitration points, so a handler may be entered right after the instruction that just completed. `bad_op_i` reports an undecodable opcode together with the number of bytes consumed so far.

Once an entry is chosen, the block runs the whole entry sequence on its own. It stores three words on the stack through a simple word memory port with a request/acknowledge handshake. It then fetches the handler offset and segment from the vector table. Finally, in a single cycle, it writes back the stack pointer, the flags with interrupt-enable and trap cleared, and the new code segment and instruction pointer. Physical addresses are formed as segment × 16 + offset. `busy_o` stays high from the first cycle of the sequence to its last.

Top module: `irq_entry_seq`

## Requirements
- R1: When a non-maskable request and a maskable request are both pending at an arbitration point, the non-maskable one (vector parameter, default 2) is entered first. The maskable one remains pending.
- R2: A maskable request is entered only while the interrupt-enable flag (flags bit 9) is 1. While the hold-off condition is set, no entry of any kind is taken at head or tail.
- R3: `head_i` arbitrates only the non-maskable and maskable requests. `tail_i` also considers the single-step trap. Either point can start an entry.
- R4: Each entry writes three words, in this order: the flags word to SS:SP-2, CS to SS:SP-4, and the return IP to SS:SP-6. The memory address stays stable until `mem_ack_i`.
- R5: The flags word written back has bit 9 (interrupt-enable) and bit 8 (trap) cleared and all other bits unchanged. The stack pointer written back is the entry SP minus 6.
- R6: For vector n, the new IP is read from physical address 4n and the new CS from 4n+2. Both are loaded in the final cycle, together with SP and flags.
- R7: Accepting a maskable request pulses `irq_ack_o` for one cycle, with `irq_ack_num_o` set to its number, and clears the pending request. Accepting a non-maskable request clears its pending bit.
- R8: At `tail_i`, a single-step trap (vector parameter, default 1) is taken if flags bit 8 was set when sampled at the preceding `head_i` and no hold-off is active. Under the same condition, a non-maskable or maskable entry is followed at once by a single-step entry that stores the handler's CS:IP.
- R9: `bad_op_i` enters the invalid-opcode vector (parameter, default 6) and stores IP + `op_len_i` as the return IP.
- R10: A `head_i` that starts no entry clears the hold-off condition.
- R11: `busy_o` is 1 for the whole entry sequence, and the memory request is only ever raised while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nmi_req_i | input | 1 | Raise a non-maskable request |
| irq_req_i | input | 1 | Raise a maskable request |
| irq_num_i | input | 8 | Number of the raised maskable request (nonzero) |
| hold_off_i | input | 1 | Set the hold-off condition |
| head_i | input | 1 | Boundary before an instruction starts |
| tail_i | input | 1 | Boundary after an instruction retires |
| bad_op_i | input | 1 | Invalid opcode seen |
| op_len_i | input | 16 | Bytes of the instruction consumed so far |
| flags_i | input | 16 | Current flags word |
| sp_i | input | 16 | Current stack pointer |
| ss_i | input | 16 | Current stack segment |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| flags_we_o | output | 1 | Write flags_o to flags |
| flags_o | output | 16 | New flags word |
| sp_we_o | output | 1 | Write sp_o to the stack pointer |
| sp_o | output | 16 | New stack pointer |
| csip_we_o | output | 1 | Load cs_o:ip_o |
| cs_o | output | 16 | Handler segment |
| ip_o | output | 16 | Handler offset |
| irq_ack_o | output | 1 | Maskable request acknowledged |
| irq_ack_num_o | output | 8 | Number being acknowledged |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access completes |
| busy_o | output | 1 | Entry sequence in progress |

## Verification
The bench builds the block with its default parameters: a 20-bit physical address, 16-bit words, 8-bit interrupt numbers, flag bits 8 and 9, and vectors 2, 1 and 6. With SS at 0x0040 and SP at 0x0400, every push lands just below physical 0x800, clear of the vector table. A maskable number of 0x21 makes the vector read reach past the first 128 bytes, so the ×4 scaling is exercised beyond the low bits. The default vectors place the single-step, non-maskable and invalid-opcode handlers at distinct table entries. As a result, a chained pair of entries shows up in the scoreboard as two separate read pairs.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP, ST_RD_IP, ST_RD_CS, ST_LOAD
    } ent_state_e;

    typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_IRQ, SRC_STEP} ent_src_e;
endpackage

// File: rtl/entry_pick.sv
module entry_pick
    import irq_entry_pkg::*;
#(
    parameter int NUM_W = 8
) (
    input  logic             nmi_pend,
    input  logic [NUM_W-1:0] irq_pend,
    input  logic             if_flag,
    input  logic             inhibit,
    input  logic             tf_start,
    input  logic             allow_step,
    output ent_src_e         src
);
    // fixed order: non-maskable, maskable, single-step
    always_comb begin
        src = SRC_NONE;
        if (!inhibit) begin
            if (nmi_pend)                       src = SRC_NMI;
            else if (irq_pend != '0 && if_flag) src = SRC_IRQ;
            else if (allow_step && tf_start)    src = SRC_STEP;
        end
    end
endmodule

// File: rtl/entry_addr.sv
module entry_addr #(
    parameter int DW    = 16,
    parameter int AW    = 20,
    parameter int SEGSH = 4
) (
    input  logic [DW-1:0] seg,
    input  logic [DW-1:0] off,
    output logic [AW-1:0] phys
);
    assign phys = (AW'(seg) << SEGSH) + AW'(off);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int NUM_W    = 8,
    parameter int NMI_VEC  = 2,
    parameter int STEP_VEC = 1,
    parameter int BAD_VEC  = 6,
    parameter int TF_BIT   = 8,
    parameter int IF_BIT   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req_i,
    input  logic             irq_req_i,
    input  logic [NUM_W-1:0] irq_num_i,
    input  logic             hold_off_i,
    input  logic             head_i,
    input  logic             tail_i,
    input  logic             bad_op_i,
    input  logic [DW-1:0]    op_len_i,
    input  logic [DW-1:0]    flags_i,
    input  logic [DW-1:0]    sp_i,
    input  logic [DW-1:0]    ss_i,
    input  logic [DW-1:0]    cs_i,
    input  logic [DW-1:0]    ip_i,
    output logic             flags_we_o,
    output logic [DW-1:0]    flags_o,
    output logic             sp_we_o,
    output logic [DW-1:0]    sp_o,
    output logic             csip_we_o,
    output logic [DW-1:0]    cs_o,
    output logic [DW-1:0]    ip_o,
    output logic             irq_ack_o,
    output logic [NUM_W-1:0] irq_ack_num_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_ack_i,
    output logic             busy_o
);
    localparam int          WORD_B  = 2;
    localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << TF_BIT) | (DW'(1) << IF_BIT));

    typedef struct packed {
        ent_state_e       st;
        logic [DW-1:0]    sp;
        logic [DW-1:0]    ss;
        logic [DW-1:0]    cs;
        logic [DW-1:0]    ip;
        logic [DW-1:0]    fl;
        logic [NUM_W-1:0] vec;
        logic             nmi_p;
        logic [NUM_W-1:0] irq_p;
        logic             inh;
        logic             tf0;
        logic             chain;
        logic             ack;
        logic [NUM_W-1:0] ack_num;
    } seq_t;

    seq_t q, d;
    ent_src_e pick;
    logic tf_now, is_push, is_read;
    logic [AW-1:0] push_addr, vec_addr;
    logic [DW-1:0] vec_off;

    assign tf_now = head_i ? flags_i[TF_BIT] : q.tf0;

    entry_pick #(.NUM_W(NUM_W)) u_pick (
        .nmi_pend  (q.nmi_p),
        .irq_pend  (q.irq_p),
        .if_flag   (flags_i[IF_BIT]),
        .inhibit   (q.inh),
        .tf_start  (tf_now),
        .allow_step(tail_i),
        .src       (pick)
    );

    assign vec_off = (DW'(q.vec) << 2) + ((q.st == ST_RD_CS) ? DW'(WORD_B) : '0);

    entry_addr #(.DW(DW), .AW(AW)) u_push_addr (
        .seg (q.ss),
        .off (q.sp - DW'(WORD_B)),
        .phys(push_addr)
    );

    entry_addr #(.DW(DW), .AW(AW)) u_vec_addr (
        .seg ('0),
        .off (vec_off),
        .phys(vec_addr)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        if (head_i) d.tf0 = flags_i[TF_BIT];
        unique case (q.st)
            ST_IDLE: begin
                if ((head_i || tail_i) && pick != SRC_NONE) begin
                    d.st    = ST_PUSH_F;
                    d.sp    = sp_i;
                    d.ss    = ss_i;
                    d.cs    = cs_i;
                    d.ip    = ip_i;
                    d.fl    = flags_i;
                    d.chain = (pick != SRC_STEP) && tf_now;
                    if (pick == SRC_NMI) begin
                        d.vec   = NUM_W'(NMI_VEC);
                        d.nmi_p = 1'b0;
                    end else if (pick == SRC_IRQ) begin
                        d.vec     = q.irq_p;
                        d.irq_p   = '0;
                        d.ack     = 1'b1;
                        d.ack_num = q.irq_p;
                    end else begin
                        d.vec = NUM_W'(STEP_VEC);
                    end
                end else if (head_i) begin
                    d.inh = 1'b0;
                end else if (bad_op_i) begin
                    d.st    = ST_PUSH_F;
                    d.sp    = sp_i;
                    d.ss    = ss_i;
                    d.cs    = cs_i;
                    d.ip    = ip_i + op_len_i;
                    d.fl    = flags_i;
                    d.chain = 1'b0;
                    d.vec   = NUM_W'(BAD_VEC);
                end
            end
            ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: begin
                if (mem_ack_i) begin
                    d.sp = q.sp - DW'(WORD_B);
                    d.st = (q.st == ST_PUSH_F)  ? ST_PUSH_CS :
                           (q.st == ST_PUSH_CS) ? ST_PUSH_IP : ST_RD_IP;
                    if (q.st == ST_PUSH_IP) d.fl = q.fl & CLR_MASK;
                end
            end
            ST_RD_IP: begin
                if (mem_ack_i) begin
                    d.ip = mem_rdata_i;
                    d.st = ST_RD_CS;
                end
            end
            ST_RD_CS: begin
                if (mem_ack_i) begin
                    d.cs = mem_rdata_i;
                    d.st = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (q.chain) begin
                    d.chain = 1'b0;
                    d.vec   = NUM_W'(STEP_VEC);
                    d.st    = ST_PUSH_F;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        // new requests win over a same-cycle acceptance
        if (nmi_req_i)  d.nmi_p = 1'b1;
        if (irq_req_i)  d.irq_p = irq_num_i;
        if (hold_off_i) d.inh   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign is_push = (q.st == ST_PUSH_F) || (q.st == ST_PUSH_CS) || (q.st == ST_PUSH_IP);
    assign is_read = (q.st == ST_RD_IP) || (q.st == ST_RD_CS);

    assign busy_o        = (q.st != ST_IDLE);
    assign mem_req_o     = is_push || is_read;
    assign mem_we_o      = is_push;
    assign mem_addr_o    = is_push ? push_addr : vec_addr;
    assign mem_wdata_o   = (q.st == ST_PUSH_F)  ? q.fl :
                           (q.st == ST_PUSH_CS) ? q.cs : q.ip;
    assign flags_we_o    = (q.st == ST_LOAD);
    assign sp_we_o       = (q.st == ST_LOAD);
    assign csip_we_o     = (q.st == ST_LOAD);
    assign flags_o       = q.fl;
    assign sp_o          = q.sp;
    assign cs_o          = q.cs;
    assign ip_o          = q.ip;
    assign irq_ack_o     = q.ack;
    assign irq_ack_num_o = q.ack_num;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int NUM_W  = 8,
    parameter int TF_BIT = 8,
    parameter int IF_BIT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             mem_req_o,
    input logic             mem_ack_i,
    input logic             mem_we_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [DW-1:0]    mem_wdata_o,
    input logic             flags_we_o,
    input logic [DW-1:0]    flags_o,
    input logic             csip_we_o,
    input logic             irq_ack_o,
    input logic [NUM_W-1:0] irq_ack_num_o
);
    assert_req_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_flags_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we_o |-> (!flags_o[TF_BIT] && !flags_o[IF_BIT]));

    assert_ends_with_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(csip_we_o));

    assert_ack_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (busy_o && irq_ack_num_o != '0));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .AW(AW), .DW(DW), .NUM_W(NUM_W), .TF_BIT(TF_BIT), .IF_BIT(IF_BIT)
) u_chk (.*);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic nmi_req = 0, irq_req = 0, hold_off = 0, head = 0, tail = 0, bad_op = 0;
    logic [7:0]  irq_num = 0;
    logic [15:0] op_len = 0;
    logic [15:0] r_fl = 0, r_sp = 16'h0400, r_ss = 16'h0040, r_cs = 16'h3000, r_ip = 16'h0100;
    logic flags_we, sp_we, csip_we, irq_ack, mem_req, mem_we, busy;
    logic [15:0] flags_o, sp_o, cs_o, ip_o, mem_wdata, mem_rdata;
    logic [7:0]  irq_ack_num;
    logic [19:0] mem_addr;
    logic        mem_ack;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .irq_req_i(irq_req),
        .irq_num_i(irq_num), .hold_off_i(hold_off), .head_i(head), .tail_i(tail),
        .bad_op_i(bad_op), .op_len_i(op_len), .flags_i(r_fl), .sp_i(r_sp),
        .ss_i(r_ss), .cs_i(r_cs), .ip_i(r_ip), .flags_we_o(flags_we),
        .flags_o(flags_o), .sp_we_o(sp_we), .sp_o(sp_o), .csip_we_o(csip_we),
        .cs_o(cs_o), .ip_o(ip_o), .irq_ack_o(irq_ack), .irq_ack_num_o(irq_ack_num),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .busy_o(busy)
    );

    // word memory: ack one cycle after request
    logic [15:0] mem [0:2047];
    logic ack_q = 1'b0;
    assign mem_ack   = ack_q;
    assign mem_rdata = mem[mem_addr[11:1]];
    always @(posedge clk) begin
        if (mem_req && mem_we && ack_q) mem[mem_addr[11:1]] <= mem_wdata;
        ack_q <= mem_req && !ack_q;
    end

    int checks = 0, errors = 0;
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct { int kind; logic [19:0] a; logic [15:0] b, c, e; string req; } sb_t;
    sb_t sbq[$];

    // expectation model for one entry
    task automatic expect_entry(input int vec, input logic [15:0] ret_ip, input string req);
        logic [19:0] base;
        base = {r_ss, 4'h0};
        sbq.push_back('{0, base + 20'(r_sp - 16'd2), r_fl, 0, 0, "R4"});
        sbq.push_back('{0, base + 20'(r_sp - 16'd4), r_cs, 0, 0, "R4"});
        sbq.push_back('{0, base + 20'(r_sp - 16'd6), ret_ip, 0, 0, {"R4 ", req}});
        sbq.push_back('{1, 20'(vec * 4), 0, 0, 0, {"R6 ", req}});
        sbq.push_back('{1, 20'(vec * 4 + 2), 0, 0, 0, {"R6 ", req}});
        r_cs = 16'h2000 + 16'(vec);
        r_ip = 16'h1000 + 16'(vec);
        r_sp = r_sp - 16'd6;
        r_fl = r_fl & 16'hFCFF;
        sbq.push_back('{2, 20'(r_sp), r_cs, r_ip, r_fl, {"R5 R6 ", req}});
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && ((mem_req && mem_ack) || csip_we)) begin
            if (sbq.size() == 0) chk(0, "R11 unexpected activity", {12'h0, mem_addr}, 0);
            else begin
                sb_t it;
                it = sbq.pop_front();
                if (csip_we) begin
                    chk(it.kind == 2 && cs_o == it.b && ip_o == it.c, {it.req, " cs:ip"},
                        {cs_o, ip_o}, {it.b, it.c});
                    chk(sp_we && sp_o == it.a[15:0], "R5 sp", sp_o, it.a);
                    chk(flags_we && flags_o == it.e, "R5 flags", flags_o, it.e);
                end else if (it.kind == 0) begin
                    chk(mem_we && mem_addr == it.a && mem_wdata == it.b, {it.req, " push"},
                        {mem_addr[15:0], mem_wdata}, {it.a[15:0], it.b});
                end else begin
                    chk(!mem_we && mem_addr == it.a && it.kind == 1, {it.req, " vector read"},
                        mem_addr, it.a);
                end
            end
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 200) begin @(negedge clk); n++; end
        chk(!busy && sbq.size() == 0, "R11 sequence completes", sbq.size(), 0);
    endtask

    task automatic no_entry(input string req);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req, req, busy, 0);
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int v = 0; v < 64; v++) begin
            mem[v * 2]     = 16'h1000 + 16'(v);
            mem[v * 2 + 1] = 16'h2000 + 16'(v);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !irq_ack, "R11 reset idle", busy, 0);
        rst_n = 1'b1;

        // R7: maskable entry at tail, ack with number
        r_fl = 16'h0200;
        irq_num = 8'h21; pulse(irq_req);
        @(negedge clk) tail = 1;
        @(negedge clk) tail = 0;
        chk(irq_ack && irq_ack_num == 8'h21, "R7 ack number", irq_ack_num, 8'h21);
        chk(busy, "R11 busy during entry", busy, 1);
        expect_entry(8'h21, 16'h0100, "R3 R7 tail irq");
        wait_idle();
        r_fl = 16'h0200;
        pulse(tail);
        no_entry("R7 irq pending cleared");

        // R2: masked by interrupt-enable
        r_fl = 16'h0000;
        irq_num = 8'h21; pulse(irq_req);
        pulse(tail);
        no_entry("R2 irq masked");
        r_fl = 16'h0200;
        pulse(tail);
        expect_entry(8'h21, r_ip, "R2 irq after enable");
        wait_idle();

        // R1: priority, then R7 pending NMI cleared
        r_fl = 16'h0200;
        irq_num = 8'h21; pulse(irq_req);
        pulse(nmi_req);
        pulse(tail);
        expect_entry(2, r_ip, "R1 nmi first");
        wait_idle();
        r_fl = 16'h0200;
        pulse(tail);
        expect_entry(8'h21, r_ip, "R1 R7 irq second");
        wait_idle();

        // R2 / R10: hold-off blocks, head clears it
        pulse(hold_off);
        pulse(nmi_req);
        pulse(tail);
        no_entry("R2 hold-off blocks nmi");
        pulse(head);
        no_entry("R10 head under hold-off takes nothing");
        pulse(tail);
        expect_entry(2, r_ip, "R10 nmi after clear");
        wait_idle();

        // R3 / R8: single step only at tail
        r_fl = 16'h0100;
        pulse(head);
        no_entry("R3 head takes no single-step");
        pulse(tail);
        expect_entry(1, r_ip, "R8 step at tail");
        wait_idle();

        // R8: trap flag sampled at head
        r_fl = 16'h0000;
        pulse(head);
        r_fl = 16'h0100;
        pulse(tail);
        no_entry("R8 tf sampled at start");

        // R8 chaining after a head NMI entry
        r_fl = 16'h0300;
        pulse(nmi_req);
        pulse(head);
        expect_entry(2, r_ip, "R3 R8 head nmi");
        expect_entry(1, r_ip, "R8 chained step");
        wait_idle();

        // R9: invalid opcode
        r_fl = 16'h0000; r_ip = 16'h0100; r_cs = 16'h3000;
        op_len = 16'd3;
        pulse(bad_op);
        expect_entry(6, 16'h0103, "R9 invalid opcode");
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule